// File: doc/BRIEF.md
# Byte-Order Aware Data Holding Buffer

This block sits between a 16-bit data register seen by software and a byte-wide transfer sequencer. It holds up to four bytes. On the transmit side the host fills it with 16-bit writes, and the last write of a message may be a single byte. The sequencer then takes bytes one at a time, oldest first. On the receive side the sequencer pushes bytes as they arrive, and the host drains them two at a time with 16-bit reads.

A byte-order input selects how each 16-bit access maps to bytes on the wire. With the input low, the low byte of a 16-bit word is the earlier byte. With it high, the high byte is the earlier byte. The block also keeps five sticky status flags. The sequencer sets most of them. The data accesses clear some of them, and the block itself sets the single-byte flag. After every read the block emits a pulse that lets the sequencer resume. It emits a second pulse when a read drains the buffer while the controller acts as master receiver. The owner of the master bit uses that pulse to set access-ready and drop mastership.

Top module: `dbuf_top`

## Requirements
- R1: A 16-bit write is accepted only when at most 2 transmit bytes are pending, and it then raises the transmit level by 2. With 3 or 4 bytes pending, the write leaves the level, the buffered bytes and the flags unchanged.
- R2: With `big_end`=0 the sequencer receives `host_wdata[7:0]` before `host_wdata[15:8]`. With `big_end`=1 it receives `host_wdata[15:8]` first.
- R3: An 8-bit write (`host_wr_byte`=1) follows the same acceptance rule as R1. It adds `host_wdata[7:0]` as one pending byte, which is sent after all bytes pending before it.
- R4: `tx_byte` shows the oldest pending byte, or 0 when none is pending. Each `tx_pop` lowers the transmit level by 1. A pop at level 0 has no effect.
- R5: An accepted write clears transmit-underflow. If more than 2 bytes are pending after the write, it also clears transmit-ready.
- R6: Received bytes are kept in arrival order. A read returns the two oldest. With `big_end`=0 the first-arrived byte is in `host_rdata[7:0]`. With `big_end`=1 it is in `host_rdata[15:8]`. Byte lanes that are not held read as zero.
- R7: A read with exactly 1 byte held sets the single-byte flag and empties the buffer. A read with 2 held empties it. A read with 3 or 4 held lowers the level by 2 and moves the remaining bytes to the front.
- R8: A read with nothing held returns 0 and leaves the receive level at 0.
- R9: Every read clears receive-overrun and pulses `seq_resume` in the next cycle. A read that leaves the level at 0 clears receive-ready. If `master_rx` is high during that read, `rx_drained` pulses in the next cycle.
- R10: The `status` bits are: bit0 transmit-ready, bit1 receive-ready, bit2 transmit-underflow, bit3 receive-overrun, bit4 single-byte. A `set_*` input sets its flag and a `flag_clr` bit clears that flag. When a set and any clear hit the same flag in the same cycle, the set wins.
- R11: A push with 4 bytes held and no read in the same cycle is ignored.
- R12: After reset both levels, `status`, `tx_byte`, `host_rdata` and both pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| big_end | input | 1 | Byte order: 1 = high byte is the earlier byte |
| master_rx | input | 1 | Controller is currently master receiver |
| host_wr | input | 1 | Data register write strobe |
| host_wr_byte | input | 1 | Write size: 1 = 8-bit, 0 = 16-bit |
| host_wdata | input | DW | Write data |
| host_rd | input | 1 | Data register read strobe |
| host_rdata | output | DW | Read data, valid in the strobe cycle |
| tx_pop | input | 1 | Sequencer takes one transmit byte |
| tx_byte | output | 8 | Oldest pending transmit byte |
| tx_level | output | CW | Pending transmit bytes |
| rx_push | input | 1 | Sequencer delivers one received byte |
| rx_byte | input | 8 | Received byte |
| rx_level | output | CW | Held receive bytes |
| set_tx_rdy | input | 1 | Set transmit-ready |
| set_rx_rdy | input | 1 | Set receive-ready |
| set_tx_udf | input | 1 | Set transmit-underflow |
| set_rx_ovr | input | 1 | Set receive-overrun |
| flag_clr | input | 5 | Software clear, one bit per flag |
| status | output | 5 | Sticky flags, layout in R10 |
| rx_drained | output | 1 | Pulse: buffer drained in master-receive |
| seq_resume | output | 1 | Pulse: a read happened, sequencer may go on |

## Verification
The bench targets the edge of the acceptance rule. A 16-bit or 8-bit write at a level of 3 or 4 must be dropped. A design that compared with the wrong bound would overwrite pending bytes or clear underflow by mistake. It checks byte order in both modes for writes and reads, and the mixed case of a pair followed by a trailing byte. A wrong shift there would send the trailing byte first. On the receive side it drains odd counts down to one byte. A wrong implementation would return stale upper lanes, miss the single-byte flag, or let an empty read change the level. It also checks the two pulses and set-over-clear priority, where a misordered update would drop a flag that was set in the same cycle.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
    localparam int FLAG_N    = 5;
    localparam int FL_TX_RDY = 0;
    localparam int FL_RX_RDY = 1;
    localparam int FL_TX_UDF = 2;
    localparam int FL_RX_OVR = 3;
    localparam int FL_SINGLE = 4;

    typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/dbuf_store.sv
module dbuf_store #(
    parameter int DW    = 16,
    parameter int BYTES = 4,
    localparam int W    = BYTES * 8,
    localparam int HALF = DW / 8,
    localparam int CW   = $clog2(BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          big_end,
    input  logic          host_wr,
    input  logic          host_wr_byte,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_rd,
    input  logic          tx_pop,
    input  logic          rx_push,
    input  logic [7:0]    rx_byte,
    output logic [DW-1:0] host_rdata,
    output logic [7:0]    tx_byte,
    output logic [CW-1:0] tx_cnt,
    output logic [CW-1:0] rx_cnt,
    output logic          ev_wr_ok,
    output logic          ev_tx_busy,
    output logic          ev_rx_empty,
    output logic          ev_single
);
    logic [W-1:0]  hold_q, hold_d;
    logic [CW-1:0] tcnt_q, tcnt_d, rcnt_q, rcnt_d;
    logic [DW-1:0] pair, lanes;

    // Order a 16-bit word so that the earlier byte lands in the upper lane,
    // because transmit drains from the most significant pending lane.
    for (genvar i = 0; i < HALF; i++) begin : g_pair
        assign pair[i*8 +: 8] = big_end ? host_wdata[i*8 +: 8]
                                        : host_wdata[(HALF-1-i)*8 +: 8];
    end

    // Receive lanes beyond the held count read as zero, then optional swap.
    for (genvar i = 0; i < HALF; i++) begin : g_lane
        assign lanes[i*8 +: 8] = (rcnt_q > CW'(i)) ? hold_q[i*8 +: 8] : 8'h00;
        assign host_rdata[i*8 +: 8] = big_end ? lanes[(HALF-1-i)*8 +: 8]
                                              : lanes[i*8 +: 8];
    end

    always_comb begin
        tx_byte = 8'h00;
        for (int i = 0; i < BYTES; i++) begin
            if (tcnt_q == CW'(i + 1)) tx_byte = hold_q[i*8 +: 8];
        end
    end

    always_comb begin
        hold_d    = hold_q;
        tcnt_d    = tcnt_q;
        rcnt_d    = rcnt_q;
        ev_single = 1'b0;
        ev_wr_ok  = host_wr && (tcnt_q <= CW'(BYTES - HALF));

        // transmit side
        if (tx_pop && (tcnt_q != '0)) tcnt_d = tcnt_d - CW'(1);
        if (ev_wr_ok) begin
            if (host_wr_byte) begin
                hold_d = {hold_q[W-9:0], host_wdata[7:0]};
                tcnt_d = tcnt_d + CW'(1);
            end else begin
                hold_d = {hold_q[W-DW-1:0], pair};
                tcnt_d = tcnt_d + CW'(HALF);
            end
        end
        ev_tx_busy = ev_wr_ok && (tcnt_d > CW'(BYTES - HALF));

        // receive side: read first, then a push lands behind what is left
        if (host_rd) begin
            if (rcnt_q == CW'(1)) begin
                ev_single = 1'b1;
                rcnt_d    = '0;
            end else if ((rcnt_q != '0) && (rcnt_q <= CW'(HALF))) begin
                rcnt_d = '0;
            end else if (rcnt_q > CW'(HALF)) begin
                hold_d = hold_d >> DW;
                rcnt_d = rcnt_q - CW'(HALF);
            end
        end
        ev_rx_empty = host_rd && (rcnt_d == '0);
        if (rx_push && (rcnt_d < CW'(BYTES))) begin
            for (int i = 0; i < BYTES; i++) begin
                if (rcnt_d == CW'(i)) hold_d[i*8 +: 8] = rx_byte;
            end
            rcnt_d = rcnt_d + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            tcnt_q <= '0;
            rcnt_q <= '0;
        end else begin
            hold_q <= hold_d;
            tcnt_q <= tcnt_d;
            rcnt_q <= rcnt_d;
        end
    end

    assign tx_cnt = tcnt_q;
    assign rx_cnt = rcnt_q;

    assert_full_write_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && (tcnt_q > CW'(BYTES - HALF)) && !tx_pop) |=> (tcnt_q == $past(tcnt_q)));
    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && (tcnt_q == '0) && !host_wr) |=> (tcnt_q == '0));
    assert_empty_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && (rcnt_q == '0)) |-> (host_rdata == '0));
    assert_full_push_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && (rcnt_q == CW'(BYTES)) && !host_rd) |=> (rcnt_q == CW'(BYTES)));
    assert_levels_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tcnt_q <= CW'(BYTES)) && (rcnt_q <= CW'(BYTES)));
endmodule

// File: rtl/dbuf_flags.sv
module dbuf_flags
    import dbuf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_vec_t set_i,
    input  flag_vec_t clr_i,
    output flag_vec_t flags_o
);
    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags_o[i] <= 1'b0;
            else        flags_o[i] <= (flags_o[i] & ~clr_i[i]) | set_i[i];
        end
    end

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/dbuf_top.sv
module dbuf_top
    import dbuf_pkg::*;
#(
    parameter int DW    = 16,
    parameter int BYTES = 4,
    localparam int CW   = $clog2(BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_end,
    input  logic              master_rx,
    input  logic              host_wr,
    input  logic              host_wr_byte,
    input  logic [DW-1:0]     host_wdata,
    input  logic              host_rd,
    output logic [DW-1:0]     host_rdata,
    input  logic              tx_pop,
    output logic [7:0]        tx_byte,
    output logic [CW-1:0]     tx_level,
    input  logic              rx_push,
    input  logic [7:0]        rx_byte,
    output logic [CW-1:0]     rx_level,
    input  logic              set_tx_rdy,
    input  logic              set_rx_rdy,
    input  logic              set_tx_udf,
    input  logic              set_rx_ovr,
    input  logic [FLAG_N-1:0] flag_clr,
    output logic [FLAG_N-1:0] status,
    output logic              rx_drained,
    output logic              seq_resume
);
    logic      ev_wr_ok, ev_tx_busy, ev_rx_empty, ev_single;
    flag_vec_t fset, fclr;

    dbuf_store #(.DW(DW), .BYTES(BYTES)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .big_end     (big_end),
        .host_wr     (host_wr),
        .host_wr_byte(host_wr_byte),
        .host_wdata  (host_wdata),
        .host_rd     (host_rd),
        .tx_pop      (tx_pop),
        .rx_push     (rx_push),
        .rx_byte     (rx_byte),
        .host_rdata  (host_rdata),
        .tx_byte     (tx_byte),
        .tx_cnt      (tx_level),
        .rx_cnt      (rx_level),
        .ev_wr_ok    (ev_wr_ok),
        .ev_tx_busy  (ev_tx_busy),
        .ev_rx_empty (ev_rx_empty),
        .ev_single   (ev_single)
    );

    always_comb begin
        fset            = '0;
        fset[FL_TX_RDY] = set_tx_rdy;
        fset[FL_RX_RDY] = set_rx_rdy;
        fset[FL_TX_UDF] = set_tx_udf;
        fset[FL_RX_OVR] = set_rx_ovr;
        fset[FL_SINGLE] = ev_single;

        fclr            = flag_clr;
        fclr[FL_TX_RDY] = flag_clr[FL_TX_RDY] | ev_tx_busy;
        fclr[FL_TX_UDF] = flag_clr[FL_TX_UDF] | ev_wr_ok;
        fclr[FL_RX_RDY] = flag_clr[FL_RX_RDY] | ev_rx_empty;
        fclr[FL_RX_OVR] = flag_clr[FL_RX_OVR] | host_rd;
    end

    dbuf_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (fset),
        .clr_i  (fclr),
        .flags_o(status)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_resume <= 1'b0;
            rx_drained <= 1'b0;
        end else begin
            seq_resume <= host_rd;
            rx_drained <= ev_rx_empty && master_rx;
        end
    end

    assert_read_resumes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> seq_resume);
    assert_read_clears_ovr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !set_rx_ovr) |=> !status[FL_RX_OVR]);
    assert_single_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && (rx_level == CW'(1))) |=> (status[FL_SINGLE] && (rx_level == '0 || $past(rx_push))));
    assert_write_clears_udf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && (tx_level <= CW'(BYTES - DW/8)) && !set_tx_udf) |=> !status[FL_TX_UDF]);
endmodule

// File: tb/dbuf_top_tb.sv
`timescale 1ns/1ps
module dbuf_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_end = 0, master_rx = 0;
    logic        host_wr = 0, host_wr_byte = 0, host_rd = 0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        tx_pop = 0, rx_push = 0;
    logic [7:0]  tx_byte, rx_byte = '0;
    logic [2:0]  tx_level, rx_level;
    logic        set_tx_rdy = 0, set_rx_rdy = 0, set_tx_udf = 0, set_rx_ovr = 0;
    logic [4:0]  flag_clr = '0;
    logic [4:0]  status;
    logic        rx_drained, seq_resume;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dbuf_top u_dut (
        .clk(clk), .rst_n(rst_n), .big_end(big_end), .master_rx(master_rx),
        .host_wr(host_wr), .host_wr_byte(host_wr_byte), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_level(tx_level),
        .rx_push(rx_push), .rx_byte(rx_byte), .rx_level(rx_level),
        .set_tx_rdy(set_tx_rdy), .set_rx_rdy(set_rx_rdy),
        .set_tx_udf(set_tx_udf), .set_rx_ovr(set_rx_ovr),
        .flag_clr(flag_clr), .status(status),
        .rx_drained(rx_drained), .seq_resume(seq_resume)
    );

    // {big_end, word, first byte out, second byte out}
    localparam logic [39:0] TXV [0:3] = '{
        40'h00_12AB_AB_12, 40'h01_12AB_12_AB,
        40'h00_F00F_0F_F0, 40'h01_8001_80_01 };
    // {big_end, first byte in, second byte in, expected read word}
    localparam logic [39:0] RXV [0:3] = '{
        40'h00_11_22_2211, 40'h01_11_22_1122,
        40'h00_FF_00_00FF, 40'h01_5A_C3_5AC3 };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(bit bytew, logic [15:0] d);
        @(negedge clk);
        host_wr = 1; host_wr_byte = bytew; host_wdata = d;
        @(negedge clk);
        host_wr = 0; host_wr_byte = 0;
    endtask

    task automatic pop();
        @(negedge clk); tx_pop = 1;
        @(negedge clk); tx_pop = 0;
    endtask

    task automatic push(logic [7:0] b);
        @(negedge clk); rx_push = 1; rx_byte = b;
        @(negedge clk); rx_push = 0;
    endtask

    task automatic rd(output logic [15:0] d);
        @(negedge clk); host_rd = 1;
        #1 d = host_rdata;
        @(negedge clk); host_rd = 0;
    endtask

    task automatic flags(logic [3:0] s, logic [4:0] c);
        @(negedge clk);
        {set_rx_ovr, set_tx_udf, set_rx_rdy, set_tx_rdy} = s;
        flag_clr = c;
        @(negedge clk);
        {set_rx_ovr, set_tx_udf, set_rx_rdy, set_tx_rdy} = '0;
        flag_clr = '0;
    endtask

    task automatic pop_chk(string req, logic [7:0] exp);
        chk(req, tx_byte, exp);
        pop();
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk("R12 tx_level", tx_level, 0);
        chk("R12 rx_level", rx_level, 0);
        chk("R12 status", status, 0);
        chk("R12 tx_byte", tx_byte, 0);
        chk("R12 rdata", host_rdata, 0);
        chk("R12 pulses", {rx_drained, seq_resume}, 0);

        // R2 table: byte order on transmit
        for (int i = 0; i < 4; i++) begin
            big_end = TXV[i][32];
            wr(0, TXV[i][31:16]);
            chk("R1 level+2", tx_level, 2);
            pop_chk("R2 first", TXV[i][15:8]);
            pop_chk("R2 second", TXV[i][7:0]);
            chk("R4 drained", tx_level, 0);
        end
        // R6 table: byte order on receive
        for (int i = 0; i < 4; i++) begin
            big_end = RXV[i][32];
            push(RXV[i][31:24]);
            push(RXV[i][23:16]);
            rd(d);
            chk("R6 read word", d, RXV[i][15:0]);
            chk("R7 two emptied", rx_level, 0);
        end

        // R3 trailing byte and R1 ignore at level 3
        big_end = 0;
        wr(0, 16'h2211);
        wr(1, 16'hEE33);
        chk("R3 level", tx_level, 3);
        wr(0, 16'h5544);
        chk("R1 ignored at 3", tx_level, 3);
        wr(1, 16'h0066);
        chk("R3 ignored at 3", tx_level, 3);
        pop_chk("R3 order 1", 8'h11);
        pop_chk("R3 order 2", 8'h22);
        pop_chk("R3 order 3", 8'h33);
        chk("R4 empty byte", tx_byte, 0);
        pop();
        chk("R4 pop at zero", tx_level, 0);

        // R5 flag effects of writes
        flags(4'b0101, 5'b0);
        wr(0, 16'h0201);
        chk("R5 udf cleared", status[2], 0);
        chk("R5 rdy kept at 2", status[0], 1);
        flags(4'b0100, 5'b0);
        wr(0, 16'h0403);
        chk("R5 rdy cleared at 4", status[0], 0);
        chk("R5 udf cleared", status[2], 0);
        flags(4'b0100, 5'b0);
        wr(0, 16'h0605);
        chk("R1 ignored keeps udf", status[2], 1);
        chk("R1 ignored level 4", tx_level, 4);
        pop_chk("R1 data kept 1", 8'h01);
        pop_chk("R1 data kept 2", 8'h02);
        pop_chk("R1 data kept 3", 8'h03);
        pop_chk("R1 data kept 4", 8'h04);

        // R6/R7 odd and full drains, R11 overflow
        for (int i = 1; i <= 5; i++) push(8'hA0 + 8'(i));
        chk("R11 level capped", rx_level, 4);
        rd(d);
        chk("R6 first pair", d, 16'hA2A1);
        chk("R7 level 2 left", rx_level, 2);
        rd(d);
        chk("R11 fifth dropped", d, 16'hA4A3);
        push(8'hB1); push(8'hB2); push(8'hB3);
        rd(d);
        chk("R7 pair of three", d, 16'hB2B1);
        chk("R7 one left", rx_level, 1);
        chk("R7 single not yet", status[4], 0);
        big_end = 1;
        rd(d);
        chk("R6 odd lane zero", d, 16'hB300);
        chk("R7 single set", status[4], 1);
        chk("R7 emptied", rx_level, 0);
        rd(d);
        chk("R8 empty read", d, 0);
        chk("R8 level stays", rx_level, 0);

        // R9 pulses and flag clears
        big_end = 0; master_rx = 1;
        flags(4'b1010, 5'b0);
        push(8'h01); push(8'h02);
        rd(d);
        chk("R9 drained pulse", rx_drained, 1);
        chk("R9 resume pulse", seq_resume, 1);
        chk("R9 rx_rdy cleared", status[1], 0);
        chk("R9 ovr cleared", status[3], 0);
        flags(4'b1010, 5'b0);
        for (int i = 0; i < 4; i++) push(8'h10);
        rd(d);
        chk("R9 no drain at 2", rx_drained, 0);
        chk("R9 rx_rdy kept", status[1], 1);
        chk("R9 ovr cleared", status[3], 0);
        rd(d);
        chk("R9 drained second", rx_drained, 1);
        master_rx = 0;
        rd(d);
        chk("R9 no drain slave", rx_drained, 0);
        chk("R9 resume empty", seq_resume, 1);
        @(negedge clk);
        chk("R9 resume one cycle", seq_resume, 0);

        // R10 software clear and set priority
        flags(4'b0000, 5'b11111);
        chk("R10 clear all", status, 0);
        flags(4'b0001, 5'b00001);
        chk("R10 set wins", status, 5'b00001);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule